// File: doc/BRIEF.md
# Capture-Compare Timer Channel

A single programmable timer channel with a 16-bit up-counter. A three-way source selector chooses what advances the counter: every system clock cycle, every sixteenth system clock cycle, or each synchronized rising edge of an external input pin. An 8-bit prescaler then divides that source by 1 to 256. The counter is compared with a reference value. On a match the channel either restarts from zero or keeps counting. The match can drive the timer output pin as a one-cycle active-low pulse or as a level toggle. That output is mixed with an external tone input to make an alert signal.

The same external pin also feeds an edge detector. On the selected transition, it latches the running count into a capture register. A gate pin can hold the channel idle: a falling gate edge opens counting and a rising gate edge closes it. Match and capture each set a sticky event flag, written to one to clear. The interrupt line is the OR of the flags whose enables are set. Software reaches all registers through a synchronous write strobe and a combinational read mux.

Top module: `cc_timer`

## Requirements
- R1: After reset the count, capture register and event flags read 0, the timer output is high and the interrupt is low.
- R2: MODE[1:0] selects the count source: 0 = every cycle, 1 = once per 16 cycles, 2 = each synchronized rising edge of the input pin, 3 = no counting.
- R3: PRESC[7:0] (address 1) holding value P makes the counter advance once per P+1 source events.
- R4: A counter advance taken while COUNT equals REF (address 2) is a match. With MODE[2]=1 the next count is 0; with MODE[2]=0 it is REF+1, wrapping modulo 2^16.
- R5: A match sets EVENT[0] and a capture sets EVENT[1] (address 5). Writing 1 to a bit clears it, writing 0 leaves it, and a same-cycle set wins. The interrupt is (EVENT[0] and MODE[3]) or (EVENT[1] and MODE[4]).
- R6: With MODE[5]=1 each match inverts the timer output. With MODE[5]=0 a match drives it low for exactly one cycle, and it is otherwise high.
- R7: The alert output equals the tone input XOR the inverted timer output, so an idle-high output leaves the tone unchanged.
- R8: MODE[7:6] selects the capture transition of the synchronized input pin: 00 none, 01 rising, 10 falling, 11 both. A capture copies COUNT into CAPT (address 4) and takes effect three clock edges after the pin changes. When capture is disabled, CAPT is left unchanged.
- R9: With MODE[8]=1 the channel counts only after a synchronized falling edge of the gate pin, and stops after a synchronized rising edge. It is closed out of reset.
- R10: With MODE[9]=0 the counter holds and the prescaler and divide-by-16 phases return to zero.
- R11: Writing address 3 loads COUNT in the next cycle, taking precedence over counting. MODE is at address 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| tin_i | input | 1 | External input pin (count source and capture) |
| gate_i | input | 1 | Gate pin |
| tone_i | input | 1 | Tone input for the alert mix |
| tout_o | output | 1 | Timer output pin |
| alert_o | output | 1 | Tone XOR inverted timer output |
| irq_o | output | 1 | Masked event interrupt |

## Verification
Register writes take effect at the edge that ends the write cycle. A match updates COUNT, EVENT[0] and the timer output at the same edge, so the interrupt and the count after a match are sampled together at the next falling edge. Pin changes reach the capture register, gate state and external source three edges later, so the bench waits at least five cycles before reading those results. Periods are measured as the distance between successive output changes, which keeps the sweeps over prescaler, reference and source free of start-up latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W    = 16;
  localparam int PSC_W    = 8;
  localparam int DIV_LOG2 = 4;
  localparam int ADDR_W   = 3;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_DIV16 = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  typedef struct packed {
    logic       run;
    logic       gate_en;
    logic [1:0] cap;
    logic       toggle;
    logic       cap_ie;
    logic       ref_ie;
    logic       restart;
    src_e       src;
  } mode_t;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd1;
  localparam logic [ADDR_W-1:0] A_REF   = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVENT = 3'd5;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], din};
    last_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
  assign fall = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int DIV_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  src_e             src,
  input  logic [PSC_W-1:0] psc,
  input  logic             gate_en,
  input  logic             ext_rise,
  input  logic             gate_rise,
  input  logic             gate_fall,
  output logic             step
);
  logic [DIV_LOG2-1:0] div_q, div_d;
  logic [PSC_W-1:0]    pcnt_q, pcnt_d;
  logic                open_q, open_d;
  logic                active, src_tick;

  always_comb begin
    open_d = open_q;
    if (gate_fall)      open_d = 1'b1;
    else if (gate_rise) open_d = 1'b0;

    active = run && (!gate_en || open_q);

    unique case (src)
      SRC_SYS:   src_tick = active;
      SRC_DIV16: src_tick = active && (div_q == '1);
      SRC_EXT:   src_tick = active && ext_rise;
      default:   src_tick = 1'b0;
    endcase

    step = src_tick && (pcnt_q == psc);

    div_d = div_q;
    if (!run)        div_d = '0;
    else if (active) div_d = div_q + 1'b1;

    pcnt_d = pcnt_q;
    if (!run)          pcnt_d = '0;
    else if (src_tick) pcnt_d = step ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pcnt_q <= '0;
      open_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      pcnt_q <= pcnt_d;
      open_q <= open_d;
    end
  end

  AST_PSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step && psc != '0) |=> (!step || psc == '0)); // R3
  AST_DIV16_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src == SRC_DIV16) |=> (!step || src != SRC_DIV16)); // R2
  AST_GATE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && gate_rise) |=> (!step || !gate_en)); // R9
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             restart,
  input  logic             toggle,
  input  logic [1:0]       cap_mode,
  input  logic             cap_rise,
  input  logic             cap_fall,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] capt,
  output logic             match,
  output logic             cap_hit,
  output logic             tout
);
  logic [CNT_W-1:0] cnt_q, cnt_d, capt_q, capt_d;
  logic             tout_q, tout_d;

  always_comb begin
    match   = step && (cnt_q == ref_val);
    cap_hit = (cap_rise && cap_mode[0]) || (cap_fall && cap_mode[1]);

    cnt_d = cnt_q;
    if (load)                 cnt_d = load_val;
    else if (match && restart) cnt_d = '0;
    else if (step)            cnt_d = cnt_q + 1'b1;

    capt_d = cap_hit ? cnt_q : capt_q;

    if (match)        tout_d = toggle ? ~tout_q : 1'b0;
    else if (!toggle) tout_d = 1'b1;
    else              tout_d = tout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      capt_q <= '0;
      tout_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      capt_q <= capt_d;
      tout_q <= tout_d;
    end
  end

  assign cnt  = cnt_q;
  assign capt = capt_q;
  assign tout = tout_q;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (match && restart && !load) |=> (cnt_q == '0)); // R4
  AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !restart && !load) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q)); // R10
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle && !tout_q && !match) |=> tout_q); // R6
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (match && toggle) |=> (tout_q != $past(tout_q))); // R6
  AST_CAPT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'b00) |=> $stable(capt_q)); // R8
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 8,
  parameter int DIV_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              tin_i,
  input  logic              gate_i,
  input  logic              tone_i,
  output logic              tout_o,
  output logic              alert_o,
  output logic              irq_o
);
  localparam int MODE_W = $bits(mode_t);
  localparam int EV_W   = 2;

  mode_t            mode_q, mode_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] ref_q, ref_d;
  logic [EV_W-1:0]  ev_q, ev_d, ev_clr;
  logic             tin_rise, tin_fall, gate_rise, gate_fall;
  logic             step, match, cap_hit, load, tout;
  logic [CNT_W-1:0] cnt, capt;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_tin_sync (
    .clk(clk), .rst_n(rst_n), .din(tin_i), .rise(tin_rise), .fall(tin_fall));

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate_i), .rise(gate_rise), .fall(gate_fall));

  tmr_tick_gen #(.PSC_W(PSC_W), .DIV_LOG2(DIV_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(mode_q.run), .src(mode_q.src), .psc(psc_q),
    .gate_en(mode_q.gate_en), .ext_rise(tin_rise), .gate_rise(gate_rise),
    .gate_fall(gate_fall), .step(step));

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load), .load_val(wdata),
    .ref_val(ref_q), .restart(mode_q.restart), .toggle(mode_q.toggle),
    .cap_mode(mode_q.cap), .cap_rise(tin_rise), .cap_fall(tin_fall),
    .cnt(cnt), .capt(capt), .match(match), .cap_hit(cap_hit), .tout(tout));

  always_comb begin
    mode_d = mode_q;
    psc_d  = psc_q;
    ref_d  = ref_q;
    ev_clr = '0;
    load   = 1'b0;
    if (wr_en) begin
      unique case (addr)
        A_MODE:  mode_d = mode_t'(wdata[MODE_W-1:0]);
        A_PRESC: psc_d  = wdata[PSC_W-1:0];
        A_REF:   ref_d  = wdata;
        A_COUNT: load   = 1'b1;
        A_EVENT: ev_clr = wdata[EV_W-1:0];
        default: ;
      endcase
    end
    ev_d = (ev_q & ~ev_clr) | {cap_hit, match};

    unique case (addr)
      A_MODE:  rdata = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      A_PRESC: rdata = {{(CNT_W-PSC_W){1'b0}}, psc_q};
      A_REF:   rdata = ref_q;
      A_COUNT: rdata = cnt;
      A_CAPT:  rdata = capt;
      A_EVENT: rdata = {{(CNT_W-EV_W){1'b0}}, ev_q};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      psc_q  <= '0;
      ref_q  <= '0;
      ev_q   <= '0;
    end else begin
      mode_q <= mode_d;
      psc_q  <= psc_d;
      ref_q  <= ref_d;
      ev_q   <= ev_d;
    end
  end

  assign tout_o  = tout;
  assign alert_o = tone_i ^ ~tout;
  assign irq_o   = (ev_q[0] && mode_q.ref_ie) || (ev_q[1] && mode_q.cap_ie);

  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> ev_q[0]); // R5
  AST_EVENT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EVENT && wdata[0] && !match) |=> !ev_q[0]); // R5
  AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (ev_q[1] && capt == $past(cnt))); // R8
endmodule

// File: tb/sim_cc_timer.sv
`timescale 1ns/1ps
module sim_cc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        tin_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        tone_i = 1'b0;
  logic        tout_o, alert_o, irq_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cc_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tin_i(tin_i), .gate_i(gate_i), .tone_i(tone_i),
    .tout_o(tout_o), .alert_o(alert_o), .irq_o(irq_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic logic [15:0] mk(input int src, input bit rst, input bit rie,
    input bit cie, input bit tog, input int ce, input bit gate, input bit run);
    mk = {6'd0, run, gate, ce[1:0], tog, cie, rie, rst, src[1:0]};
  endfunction

  task automatic setup(input logic [15:0] mode, input int psc, input int rf);
    wr(3'd0, mode & 16'h01FF);
    wr(3'd1, psc[15:0]);
    wr(3'd2, rf[15:0]);
    wr(3'd3, 16'd0);
    wr(3'd5, 16'd3);
    wr(3'd0, mode);
  endtask

  task automatic meas_toggle(output int per);
    logic prev;
    int n;
    @(negedge clk); prev = tout_o; n = 0;
    while (tout_o == prev && n < 3000) begin @(negedge clk); n++; end
    prev = tout_o; n = 0;
    do begin @(negedge clk); n++; end while (tout_o == prev && n < 3000);
    per = n;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v, c2;
    int per, n, prevc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(tout_o == 1'b1, "R1 tout", tout_o, 1);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    rd(3'd3, v); chk(v == 0, "R1 count", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 capt", v, 0);
    rd(3'd5, v); chk(v == 0, "R1 event", v, 0);
    // R7 alert with idle-high output
    chk(alert_o == 1'b0, "R7 tone0", alert_o, 0);
    tone_i = 1'b1; #1;
    chk(alert_o == 1'b1, "R7 tone1", alert_o, 1);
    tone_i = 1'b0;

    // R11 unmapped address, load of COUNT
    rd(3'd7, v); chk(v == 0, "R11 unmapped", v, 0);
    wr(3'd3, 16'd1234);
    rd(3'd3, v); chk(v == 1234, "R11 load", v, 1234);

    // R8 capture edge sweep with the counter held (R10)
    prevc = 0;
    for (int e = 0; e < 4; e++) begin
      wr(3'd0, mk(0, 0, 0, 0, 0, e, 0, 0));
      wr(3'd3, 16'(100 + e * 10));
      wr(3'd5, 16'd3);
      tin_i = 1'b1;
      repeat (5) @(negedge clk);
      rd(3'd4, v);
      if (e[0]) prevc = 100 + e * 10;
      chk(v == prevc, "R8 rise capture", v, prevc);
      rd(3'd5, v);
      chk(v[1] == e[0], "R8 rise flag", v[1], e[0]);
      wr(3'd3, 16'(200 + e * 10));
      wr(3'd5, 16'd3);
      tin_i = 1'b0;
      repeat (5) @(negedge clk);
      rd(3'd4, v);
      if (e[1]) prevc = 200 + e * 10;
      chk(v == prevc, "R8 fall capture", v, prevc);
      rd(3'd5, v);
      chk(v[1] == e[1], "R8 fall flag", v[1], e[1]);
    end
    rd(3'd3, v); chk(v == 230, "R10 held count", v, 230);

    // R2 R3 R4 R6 toggle period sweep, every-cycle source
    for (int p = 0; p < 4; p += (p == 1) ? 2 : 1) begin
      for (int r = 0; r < 5; r += (r == 1) ? 3 : 1) begin
        setup(mk(0, 1, 0, 0, 1, 0, 0, 1), p, r);
        meas_toggle(per);
        chk(per == (p + 1) * (r + 1), "R3 toggle period", per, (p + 1) * (r + 1));
        chk(alert_o == (tone_i ^ ~tout_o), "R7 mix", alert_o, tone_i ^ ~tout_o);
      end
    end

    // R2 divide-by-16 source
    setup(mk(1, 1, 0, 0, 1, 0, 0, 1), 0, 0);
    meas_toggle(per); chk(per == 16, "R2 div16", per, 16);
    setup(mk(1, 1, 0, 0, 1, 0, 0, 1), 1, 1);
    meas_toggle(per); chk(per == 64, "R2 div16 presc", per, 64);
    // R2 source 3 never counts
    setup(mk(3, 1, 0, 0, 1, 0, 0, 1), 0, 5);
    repeat (20) @(negedge clk);
    rd(3'd3, v); chk(v == 0, "R2 off source", v, 0);

    // R6 R7 pulse mode
    tone_i = 1'b1;
    for (int p = 0; p < 3; p += 2) begin
      for (int r = 1; r < 4; r += 2) begin
        setup(mk(0, 1, 0, 0, 0, 0, 0, 1), p, r);
        n = 0;
        while (tout_o != 1'b0 && n < 500) begin @(negedge clk); n++; end
        chk(alert_o == 1'b0, "R7 pulse mix", alert_o, 0);
        @(negedge clk);
        chk(tout_o == 1'b1, "R6 pulse width", tout_o, 1);
        n = 1;
        while (tout_o != 1'b0 && n < 500) begin @(negedge clk); n++; end
        chk(n == (p + 1) * (r + 1), "R6 pulse period", n, (p + 1) * (r + 1));
      end
    end
    tone_i = 1'b0;

    // R4 restart versus free-run, seen at the interrupt (R5)
    for (int m = 0; m < 2; m++) begin
      setup(mk(0, m, 1, 0, 1, 0, 0, 1), 0, 5);
      addr = 3'd3;
      n = 0;
      while (!irq_o && n < 200) begin @(negedge clk); n++; end
      #1 v = rdata;
      chk(v == (m ? 0 : 6), "R4 count after match", v, m ? 0 : 6);
    end

    // R5 event flag, mask, W1C
    setup(mk(0, 1, 0, 0, 1, 0, 0, 1), 0, 2);
    repeat (10) @(negedge clk);
    rd(3'd5, v); chk(v[0] == 1'b1, "R5 ref flag", v[0], 1);
    chk(irq_o == 1'b0, "R5 masked", irq_o, 0);
    wr(3'd0, mk(0, 1, 1, 0, 1, 0, 0, 1));
    chk(irq_o == 1'b1, "R5 enabled", irq_o, 1);
    wr(3'd0, mk(0, 1, 1, 0, 1, 0, 0, 0));
    wr(3'd5, 16'd0);
    rd(3'd5, v); chk(v[0] == 1'b1, "R5 write zero keeps", v[0], 1);
    wr(3'd5, 16'd1);
    rd(3'd5, v); chk(v[0] == 1'b0, "R5 w1c", v[0], 0);
    chk(irq_o == 1'b0, "R5 irq cleared", irq_o, 0);

    // R2 R3 external source
    setup(mk(2, 0, 0, 0, 1, 0, 0, 1), 0, 16'hFFFF);
    for (int i = 0; i < 5; i++) begin
      tin_i = 1'b1; repeat (3) @(negedge clk);
      tin_i = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk(v == 5, "R2 external edges", v, 5);
    setup(mk(2, 0, 0, 0, 1, 0, 0, 1), 1, 16'hFFFF);
    for (int i = 0; i < 6; i++) begin
      tin_i = 1'b1; repeat (3) @(negedge clk);
      tin_i = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk(v == 3, "R3 external presc", v, 3);

    // R9 gate
    setup(mk(0, 0, 0, 0, 1, 0, 1, 1), 0, 16'hFFFF);
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk(v == 0, "R9 closed", v, 0);
    gate_i = 1'b0;
    repeat (12) @(negedge clk);
    rd(3'd3, v); chk(v >= 5, "R9 opened", v, 5);
    gate_i = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd3, c2);
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk(v == c2, "R9 closed again", v, c2);

    finish_run();
  end
endmodule